// File: doc/BRIEF.md
# S-Curve Soft-Mute Envelope Controller

This block generates a digital gain envelope that fades an audio channel between full level and silence along an S-shaped curve. The gain moves slowly near both ends and fastest through the middle, which softens the start and finish of each fade. A mute is requested by pulling an active-low pin low or by committing a mute bit through a register write. Both requests produce the same fade. A 2-bit setting selects one of four fade durations.

Each fade always runs to its end. A request that changes while a fade is running is looked at only after the fade finishes. One instance serves a stereo pair. In stereo mode a single request fades both channels together. In split mode each channel has its own committed bus bit, and the pin still fades both. The block outputs a 16-bit unsigned gain per channel and also applies that gain to a signed 24-bit sample stream, with rounding and saturation.

Top module: `smute_env`

## Requirements
- R1: While reset is held, and after it is released until the first fade starts, both gains read 0, `muted` reads 2'b11 and `busy` reads 2'b00.
- R2: The gain at fade position p (0 = silence, 64 = full) is floor(65535*(192*p^2 - 2*p^3)/262144) for p < 32, 0x8000 for p = 32, and 65535 minus the value at position 64-p for p > 32. A fade visits every position in order, one step per tick.
- R3: A tick occurs every BASE_DIV << ramp_sel clock cycles (4, 8, 16 or 32 with the default BASE_DIV of 4). `busy` stays high for exactly 64 tick periods per fade. The gain first changes one tick after `busy` rises.
- R4: `mute_pin_n` low requests a mute on both channels. The pin passes through a 2-stage synchronizer, and the fade starts on the first tick that sees the synchronized request, so `busy` rises 3 to BASE_DIV+2 cycles after the pin falls.
- R5: `bus_mute` takes effect only in the cycle after a cycle with `bus_we` high, when it is committed. Without `bus_we`, changes to `bus_mute` have no effect.
- R6: A fade that has started runs to its end even if the request is withdrawn. The withdrawn request is then honoured on a later tick and starts a fade back.
- R7: With `split_en` = 1, committed bus bit 0 mutes only the left channel and bit 1 mutes only the right channel.
- R8: With `split_en` = 0, committed bit 0 mutes both channels in lockstep and bit 1 is ignored.
- R9: The outputs `out_l`/`out_r` equal clamp(floor((s*(g + g[15]) + 32768) / 65536)), where s is the input sample and g is the gain at the input cycle. They are registered one cycle after `in_valid`, and `out_valid` is `in_valid` delayed by one cycle. At unity the output equals the input exactly.
- R10: `busy` and `muted` are never high together on a channel. A channel that is neither busy nor muted has gain 0xFFFF, and a fade ends only at 0 or at 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mute_pin_n | input | 1 | Active-low hardware mute request (asynchronous) |
| bus_we | input | 1 | Commit strobe for `bus_mute` |
| bus_mute | input | 2 | Software mute bits; bit 0 left or both, bit 1 right |
| split_en | input | 1 | 1 = per-channel bus mute, 0 = stereo |
| ramp_sel | input | 2 | Fade duration select |
| in_valid | input | 1 | Input sample strobe |
| in_l | input | 24 | Left signed sample |
| in_r | input | 24 | Right signed sample |
| out_valid | output | 1 | Output sample strobe |
| out_l | output | 24 | Left scaled sample |
| out_r | output | 24 | Right scaled sample |
| gain_l | output | 16 | Left gain, 0xFFFF = unity |
| gain_r | output | 16 | Right gain, 0xFFFF = unity |
| busy | output | 2 | Fade in progress, bit 0 left, bit 1 right |
| muted | output | 2 | Gain at zero, bit 0 left, bit 1 right |

## Verification
A corrupted sequencer state or position shows up on the gain ports within one tick period. It appears as a skipped or repeated curve value, a fade that stops short of 0 or 0xFFFF, or a wrong `busy` width. A bad request path shows up as a wrong channel fading, or as a fade that starts too early or never starts. A multiplier fault shows up on the very next `out_valid`. The bench therefore compares every curve step, the exact fade length and every scaled sample against values computed from the requirements.

// File: rtl/smute_pkg.sv
package smute_pkg;
  typedef enum logic [1:0] {
    ST_SILENT = 2'd0,
    ST_OPEN   = 2'd1,
    ST_FALL   = 2'd2,
    ST_RISE   = 2'd3
  } env_state_e;
endpackage

// File: rtl/smute_tick.sv
module smute_tick #(
  parameter int BASE_DIV = 4,
  parameter int SEL_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int MAX_DIV = BASE_DIV << ((1 << SEL_W) - 1);
  localparam int CW      = $clog2(MAX_DIV + 1);

  logic [CW-1:0] cnt_q, cnt_d, div;

  always_comb begin
    div   = CW'(BASE_DIV) << sel;
    tick  = (cnt_q >= div - CW'(1));
    cnt_d = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/smute_curve.sv
module smute_curve #(
  parameter int HALF   = 32,
  parameter int GAIN_W = 16,
  parameter int POS_W  = 7
) (
  input  logic [POS_W-1:0]  pos,
  output logic [GAIN_W-1:0] gain
);
  localparam int FULL  = 2 * HALF;
  localparam int IDX_W = $clog2(HALF);
  localparam logic [GAIN_W-1:0] MAXG = '1;
  localparam logic [GAIN_W-1:0] MIDG = GAIN_W'(1) << (GAIN_W - 1);

  function automatic logic [GAIN_W-1:0] lower_half(input int i);
    longint unsigned x, n, num, den;
    x   = longint'(i);
    n   = longint'(FULL);
    num = ((longint'(1) << GAIN_W) - 1) * (3 * x * x * n - 2 * x * x * x);
    den = n * n * n;
    return GAIN_W'(num / den);
  endfunction

  logic [GAIN_W-1:0] lut [HALF];

  for (genvar i = 0; i < HALF; i++) begin : g_lut
    assign lut[i] = lower_half(i);
  end

  logic [POS_W-1:0] mirror;

  always_comb begin
    mirror = POS_W'(FULL) - pos;
    if (pos < POS_W'(HALF))       gain = lut[pos[IDX_W-1:0]];
    else if (pos == POS_W'(HALF)) gain = MIDG;
    else                          gain = MAXG - lut[mirror[IDX_W-1:0]];
  end
endmodule

// File: rtl/smute_seq.sv
module smute_seq
  import smute_pkg::*;
#(
  parameter int FULL  = 64,
  parameter int POS_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             req,
  output logic [POS_W-1:0] pos,
  output logic             busy,
  output logic             muted
);
  env_state_e       st_q, st_d;
  logic [POS_W-1:0] pos_q, pos_d;

  always_comb begin
    st_d  = st_q;
    pos_d = pos_q;
    if (tick) begin
      unique case (st_q)
        ST_SILENT: if (!req) st_d = ST_RISE;
        ST_OPEN:   if (req)  st_d = ST_FALL;
        ST_FALL: begin
          pos_d = pos_q - POS_W'(1);
          if (pos_q == POS_W'(1)) st_d = ST_SILENT;
        end
        ST_RISE: begin
          pos_d = pos_q + POS_W'(1);
          if (pos_q == POS_W'(FULL - 1)) st_d = ST_OPEN;
        end
        default: st_d = ST_SILENT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_SILENT;
      pos_q <= '0;
    end else begin
      st_q  <= st_d;
      pos_q <= pos_d;
    end
  end

  assign pos   = pos_q;
  assign busy  = (st_q == ST_FALL) || (st_q == ST_RISE);
  assign muted = (st_q == ST_SILENT);
endmodule

// File: rtl/smute_mult.sv
module smute_mult #(
  parameter int SAMP_W = 24,
  parameter int GAIN_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic signed [SAMP_W-1:0] in_s,
  input  logic [GAIN_W-1:0]        gain,
  output logic signed [SAMP_W-1:0] out_s
);
  localparam int PW = SAMP_W + GAIN_W + 2;
  localparam logic signed [PW-1:0] RND  = PW'(1) << (GAIN_W - 1);
  localparam logic signed [PW-1:0] MAXS = (PW'(1) << (SAMP_W - 1)) - PW'(1);
  localparam logic signed [PW-1:0] MINS = -(PW'(1) << (SAMP_W - 1));

  logic [GAIN_W:0]           g_eff;
  logic signed [PW-1:0]      prod, shf;
  logic signed [SAMP_W-1:0]  sat, out_q, out_d;

  always_comb begin
    g_eff = {1'b0, gain} + {{GAIN_W{1'b0}}, gain[GAIN_W-1]};
    prod  = $signed(in_s) * $signed({1'b0, g_eff});
    shf   = (prod + RND) >>> GAIN_W;
    if (shf > MAXS)      sat = MAXS[SAMP_W-1:0];
    else if (shf < MINS) sat = MINS[SAMP_W-1:0];
    else                 sat = shf[SAMP_W-1:0];
    out_d = en ? sat : out_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= '0;
    else        out_q <= out_d;
  end

  assign out_s = out_q;
endmodule

// File: rtl/smute_env.sv
module smute_env #(
  parameter int SAMP_W   = 24,
  parameter int GAIN_W   = 16,
  parameter int HALF     = 32,
  parameter int BASE_DIV = 4,
  parameter int SYNC_N   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mute_pin_n,
  input  logic              bus_we,
  input  logic [1:0]        bus_mute,
  input  logic              split_en,
  input  logic [1:0]        ramp_sel,
  input  logic              in_valid,
  input  logic [SAMP_W-1:0] in_l,
  input  logic [SAMP_W-1:0] in_r,
  output logic              out_valid,
  output logic [SAMP_W-1:0] out_l,
  output logic [SAMP_W-1:0] out_r,
  output logic [GAIN_W-1:0] gain_l,
  output logic [GAIN_W-1:0] gain_r,
  output logic [1:0]        busy,
  output logic [1:0]        muted
);
  localparam int FULL  = 2 * HALF;
  localparam int POS_W = $clog2(FULL + 1);
  localparam int NCH   = 2;

  // pin synchronizer, idle level is high (no request)
  logic [SYNC_N-1:0] sync_q, sync_d;
  always_comb sync_d = {sync_q[SYNC_N-2:0], mute_pin_n};
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '1;
    else        sync_q <= sync_d;
  end
  logic pin_req;
  assign pin_req = ~sync_q[SYNC_N-1];

  // committed software mute bits
  logic [1:0] cmt_q, cmt_d;
  always_comb cmt_d = bus_we ? bus_mute : cmt_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmt_q <= '0;
    else        cmt_q <= cmt_d;
  end

  logic [NCH-1:0] req;
  always_comb begin
    req[0] = pin_req | cmt_q[0];
    req[1] = pin_req | (split_en ? cmt_q[1] : cmt_q[0]);
  end

  logic tick;
  smute_tick #(.BASE_DIV(BASE_DIV), .SEL_W(2)) u_tick (
    .clk(clk), .rst_n(rst_n), .sel(ramp_sel), .tick(tick)
  );

  logic        [GAIN_W-1:0] gain_a [NCH];
  logic signed [SAMP_W-1:0] smp_a  [NCH];
  logic signed [SAMP_W-1:0] res_a  [NCH];
  assign smp_a[0] = $signed(in_l);
  assign smp_a[1] = $signed(in_r);

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [POS_W-1:0] pos;
    smute_seq #(.FULL(FULL), .POS_W(POS_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .tick(tick), .req(req[c]),
      .pos(pos), .busy(busy[c]), .muted(muted[c])
    );
    smute_curve #(.HALF(HALF), .GAIN_W(GAIN_W), .POS_W(POS_W)) u_curve (
      .pos(pos), .gain(gain_a[c])
    );
    smute_mult #(.SAMP_W(SAMP_W), .GAIN_W(GAIN_W)) u_mult (
      .clk(clk), .rst_n(rst_n), .en(in_valid), .in_s(smp_a[c]),
      .gain(gain_a[c]), .out_s(res_a[c])
    );
  end

  logic vld_q, vld_d;
  always_comb vld_d = in_valid;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= vld_d;
  end

  assign out_valid = vld_q;
  assign out_l     = res_a[0];
  assign out_r     = res_a[1];
  assign gain_l    = gain_a[0];
  assign gain_r    = gain_a[1];
endmodule

// File: rtl/smute_env_chk.sv
module smute_env_chk #(
  parameter int SAMP_W = 24,
  parameter int GAIN_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [GAIN_W-1:0] gain_l,
  input logic [GAIN_W-1:0] gain_r,
  input logic [1:0]        busy,
  input logic [1:0]        muted,
  input logic              in_valid,
  input logic [SAMP_W-1:0] in_l,
  input logic              out_valid,
  input logic [SAMP_W-1:0] out_l
);
  a_r10_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy[0] && muted[0]) && !(busy[1] && muted[1]));

  a_r1_silent_gain_l: assert property (@(posedge clk) disable iff (!rst_n)
    muted[0] |-> gain_l == '0);

  a_r1_silent_gain_r: assert property (@(posedge clk) disable iff (!rst_n)
    muted[1] |-> gain_r == '0);

  a_r10_open_unity: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy[0] && !muted[0]) |-> gain_l == '1);

  a_r6_ends_at_endpoint: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy[0]) |-> (muted[0] || gain_l == '1));

  a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  a_r9_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  a_r9_unity_exact: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && gain_l == '1) |=> out_l == $past(in_l));
endmodule

bind smute_env smute_env_chk #(.SAMP_W(SAMP_W), .GAIN_W(GAIN_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .gain_l(gain_l), .gain_r(gain_r),
  .busy(busy), .muted(muted), .in_valid(in_valid), .in_l(in_l),
  .out_valid(out_valid), .out_l(out_l)
);

// File: tb/sim_smute_env.sv
module sim_smute_env;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst_n = 1'b0, mute_pin_n = 1'b1, bus_we = 1'b0, split_en = 1'b0;
  logic [1:0]  bus_mute = 2'b00, ramp_sel = 2'b00;
  logic        in_valid = 1'b0;
  logic [23:0] in_l = '0, in_r = '0;
  logic        out_valid;
  logic [23:0] out_l, out_r;
  logic [15:0] gain_l, gain_r;
  logic [1:0]  busy, muted;

  smute_env u0 (.*);

  int vectors = 0, miscompares = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic longint exp_gain(input int p);
    longint v;
    if (p < 32) v = (65535 * (192 * longint'(p) * p - 2 * longint'(p) * p * p)) / 262144;
    else if (p == 32) v = 32768;
    else v = 65535 - exp_gain(64 - p);
    return v;
  endfunction

  function automatic logic [23:0] scale(input logic signed [23:0] s, input logic [15:0] g);
    longint ge, p;
    ge = longint'(g) + longint'(g[15]);
    p  = (longint'(s) * ge + 32768) >>> 16;
    if (p > 8388607)  p = 8388607;
    if (p < -8388608) p = -8388608;
    return 24'(p);
  endfunction

  function automatic logic [15:0] gsel(input int ch);
    return (ch == 0) ? gain_l : gain_r;
  endfunction

  typedef struct { logic [23:0] l; logic [23:0] r; } pair_t;
  pair_t exp_q[$];

  // monitor
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R9", "unexpected out_valid", 1, 0);
      else begin
        pair_t e;
        e = exp_q.pop_front();
        chk(out_l == e.l, "R9", "out_l", longint'($signed(out_l)), longint'($signed(e.l)));
        chk(out_r == e.r, "R9", "out_r", longint'($signed(out_r)), longint'($signed(e.r)));
      end
    end
  end

  // driver: called just after a negedge
  task automatic send(input logic [23:0] l, input logic [23:0] r);
    pair_t e;
    e.l = scale(l, gain_l);
    e.r = scale(r, gain_r);
    exp_q.push_back(e);
    in_valid = 1'b1; in_l = l; in_r = r;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic commit(input logic [1:0] m);
    bus_mute = m; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wait_busy(input int ch);
    for (int i = 0; i < 20000 && !busy[ch]; i++) @(negedge clk);
  endtask

  task automatic wait_idle(input int ch);
    for (int i = 0; i < 20000 && busy[ch]; i++) @(negedge clk);
  endtask

  task automatic ramp_curve(input int ch, input bit down);
    logic [15:0] prev, cur;
    wait_busy(ch);
    prev = gsel(ch);
    for (int k = 1; k <= 64; k++) begin
      cur = gsel(ch);
      for (int i = 0; i < 20000 && cur == prev; i++) begin
        @(negedge clk);
        cur = gsel(ch);
      end
      chk(longint'(cur) == exp_gain(down ? 64 - k : k), "R2", "curve step",
          longint'(cur), exp_gain(down ? 64 - k : k));
      prev = cur;
    end
    @(negedge clk);
  endtask

  // watchdog
  int cycles = 0;
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    int width, lat;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(gain_l == 0 && gain_r == 0, "R1", "gain in reset", gain_l, 0);
    chk(muted == 2'b11, "R1", "muted in reset", muted, 3);
    chk(busy == 2'b00, "R1", "busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(muted == 2'b11 && gain_l == 0, "R1", "muted after release", muted, 3);

    // R2 rising curve, R8 lockstep in stereo
    ramp_curve(0, 1'b0);
    chk(gain_r == 16'hFFFF, "R8", "right follows left", gain_r, 65535);
    chk(muted == 2'b00 && busy == 2'b00, "R10", "open flags", {busy, muted}, 0);

    // R9 unity samples
    send(24'h7FFFFF, 24'h800000);
    send(24'hFFFFFF, 24'd5);
    send(24'd12345, -24'sd54321);

    // R3 fade length at slowest setting, R5 commit, R8 bit0 mutes both
    ramp_sel = 2'd3;
    commit(2'b01);
    wait_busy(0);
    width = 0;
    while (busy[0] && width < 5000) begin @(negedge clk); width++; end
    chk(width == 64 * 32, "R3", "busy width sel3", width, 64 * 32);
    chk(muted == 2'b11, "R8", "stereo bit0 mutes both", muted, 3);
    send(24'h7FFFFF, 24'h123456);

    // R9 rounding during a rising fade, R2 falling curve checked later
    ramp_sel = 2'd1;
    commit(2'b00);
    wait_busy(0);
    for (int i = 0; i < 12; i++) begin
      repeat (37) @(negedge clk);
      send(24'h400001 + 24'(i * 977), -24'sd1193047 + 24'(i * 311));
    end
    wait_idle(0);
    chk(gain_l == 16'hFFFF, "R3", "rise finished", gain_l, 65535);
    send(24'h000001, 24'hFFFFFE);

    // R4 pin latency, R6 withdrawn request does not abort
    ramp_sel = 2'd0;
    @(negedge clk);
    mute_pin_n = 1'b0;
    lat = 0;
    while (!busy[0] && lat < 100) begin @(negedge clk); lat++; end
    chk(lat >= 3 && lat <= 6, "R4", "pin latency", lat, 6);
    chk(busy == 2'b11, "R4", "pin fades both", busy, 3);
    mute_pin_n = 1'b1;
    wait_idle(0);
    chk(muted == 2'b11, "R6", "fade completed after withdraw", muted, 3);
    wait_busy(0);
    wait_idle(0);
    chk(gain_l == 16'hFFFF && gain_r == 16'hFFFF, "R6", "fade back to unity", gain_l, 65535);

    // R2 falling curve via pin
    mute_pin_n = 1'b0;
    ramp_curve(0, 1'b1);
    chk(muted[0] == 1'b1, "R2", "falling ends silent", muted, 3);
    mute_pin_n = 1'b1;
    wait_busy(0);
    wait_idle(0);

    // R5 no commit without bus_we
    bus_mute = 2'b11;
    repeat (200) @(negedge clk);
    chk(busy == 2'b00 && gain_l == 16'hFFFF && gain_r == 16'hFFFF, "R5",
        "uncommitted bits ignored", busy, 0);

    // R7 split mode, right only
    split_en = 1'b1;
    commit(2'b10);
    wait_busy(1);
    chk(busy == 2'b10, "R7", "only right fades", busy, 2);
    wait_idle(1);
    chk(muted == 2'b10, "R7", "right muted only", muted, 2);
    chk(gain_l == 16'hFFFF && gain_r == 16'h0000, "R7", "gains split", gain_r, 0);
    send(24'h654321, 24'h654321);
    commit(2'b00);
    wait_busy(1);
    wait_idle(1);

    // R8 stereo ignores bit1
    split_en = 1'b0;
    commit(2'b10);
    repeat (300) @(negedge clk);
    chk(busy == 2'b00 && gain_l == 16'hFFFF && gain_r == 16'hFFFF, "R8",
        "bit1 ignored in stereo", gain_r, 65535);

    repeat (5) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "all samples returned", exp_q.size(), 0);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule